// File: doc/BRIEF.md
# Halt Mode Power Sequencer

This controller takes a processor subsystem into a deep low-power halt and brings it back out. It runs on an always-on sequencing clock. When the CPU raises a halt request from its idle instruction, the core clock stays on for a short, bounded drain window. The pipeline can flush during that window, and the CPU may end it early by reporting that its pipeline is empty. The controller then gates the core and peripheral clocks and powers down the PLL. If an external crystal or resonator is the clock source, it also stops the oscillator. A keep-alive bit, sampled at halt entry, decides whether the internal oscillators and the watchdog stay powered.

Wake-up comes from a falling edge on an active-low wake pin. An asynchronous edge latch captures that edge while the clocks are stopped, and a two-flop synchroniser passes it to the state machine. Edges that arrive within a fixed blackout window after halt entry are discarded. On wake, the controller turns the oscillator back on and waits for its ready input, under a programmable timeout. Once the oscillator is stable, it re-enables the clocks, pulses a wake interrupt to the CPU and raises a sticky flag saying the PLL must be relocked. If the timeout expires first, the controller falls back into halt and sets an error flag.

Top module: `halt_seq_top`

## Requirements
- R1: After reset, the sequencer is in run mode. All six enables (`sysclk_en`, `periph_clk_en`, `pll_pwr_en`, `osc_en`, `intosc_en`, `wdog_en`) are 1, and `in_halt`, `osc_waking`, `cpu_wake_irq`, `pll_relock_req` and `osc_err` are 0.
- R2: Once a `halt_req` is accepted, `sysclk_en` stays 1 for k+1 cycles, where k is the 0-based drain cycle in which `pipe_empty` is first seen high. The window never exceeds DRAIN_MAX cycles (16 by default), and `in_halt` rises in the cycle after it ends.
- R3: While `in_halt` is 1, `sysclk_en`, `periph_clk_en` and `pll_pwr_en` are 0.
- R4: While `in_halt` is 1, `osc_en` equals the inverse of the `src_is_xtal` value sampled at the end of the drain window.
- R5: While `in_halt` is 1, `intosc_en` and `wdog_en` both equal the `wd_keep` value sampled at the end of the drain window.
- R6: Falling edges on `wake_n` during the first BLACKOUT_CYC cycles of halt (5 by default) are ignored. The controller stays in halt and `osc_waking` stays 0.
- R7: A falling edge on `wake_n` after the blackout sets `osc_waking` (with `osc_en` and `intosc_en` at 1) after exactly three rising edges of `aon_clk`, counting from the sequencing-clock half-period in which the edge occurs.
- R8: `sysclk_en` returns to 1 only in the cycle after `osc_ready` is seen during wake. In that cycle `cpu_wake_irq` is 1 for exactly one cycle, and run mode follows.
- R9: `pll_relock_req` becomes 1 in the same cycle as `cpu_wake_irq` and stays 1 until `relock_ack` is sampled high in run mode.
- R10: If `osc_ready` stays low, `osc_waking` lasts `osc_to_cfg`+1 cycles. The controller then returns to halt (`in_halt`=1) with `osc_err`=1, and `osc_err` clears on the next successful wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk | input | 1 | Always-on sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request from the CPU idle instruction |
| pipe_empty | input | 1 | CPU pipeline drained; ends the drain window early |
| wake_n | input | 1 | Asynchronous active-low wake pin (falling edge wakes) |
| src_is_xtal | input | 1 | 1 when the oscillator source is an external crystal or resonator |
| wd_keep | input | 1 | Keep internal oscillators and watchdog alive in halt |
| osc_ready | input | 1 | Oscillator stable indication |
| osc_to_cfg | input | TO_W | Oscillator wait limit; the wait lasts value+1 cycles |
| relock_ack | input | 1 | Clears the relock flag in run mode |
| sysclk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_pwr_en | output | 1 | PLL power enable |
| osc_en | output | 1 | External oscillator enable |
| intosc_en | output | 1 | Internal oscillators enable |
| wdog_en | output | 1 | Watchdog enable |
| in_halt | output | 1 | Halted (blackout or waiting for wake) |
| osc_waking | output | 1 | Waiting for the oscillator to stabilise |
| cpu_wake_irq | output | 1 | One-cycle wake interrupt to the CPU |
| pll_relock_req | output | 1 | PLL must be relocked before use |
| osc_err | output | 1 | Last wake attempt timed out |

## Verification
The bound checker checks these rules on every cycle:
- Drain length: no drain run exceeds DRAIN_MAX.
- Gating in halt: the core clock, peripheral clocks and PLL stay off throughout halt.
- Crystal shutdown: when the sampled source is a crystal, the oscillator is off on entry to halt.
- Blackout: no wake starts within the blackout window.
- Core clock return: the core clock comes back only after the oscillator reported ready, and together with the interrupt.
- Exit flags: the relock flag is present at every wake interrupt, and every timed-out wait lands back in halt with the error flag set.

The bench's scenarios are needed for the exact cycle counts and for rejection of the glitch. They cover the exact drain length as a function of when the pipeline empties, the three-edge synchroniser latency, the keep-alive and oscillator levels across several configurations, and the discarding of a glitch inside the blackout. They also cover the exact wait length on a timeout and the clearing of the relock and error flags.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_BLACK  = 3'd2,
    ST_HALT   = 3'd3,
    ST_OSCW   = 3'd4,
    ST_RESUME = 3'd5
  } hs_state_e;

  // Width of the shared phase counter: wide enough for every phase limit.
  function automatic int hs_cnt_w(input int drain_max, input int blk, input int to_w);
    int w;
    w = to_w;
    if ($clog2(drain_max) > w) w = $clog2(drain_max);
    if ($clog2(blk) > w) w = $clog2(blk);
    if (w < 1) w = 1;
    return w;
  endfunction

  // Last counter index of a phase that lasts len cycles.
  function automatic int hs_last(input int len);
    return (len > 0) ? len - 1 : 0;
  endfunction

endpackage

// File: rtl/halt_wake_capture.sv
module halt_wake_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic aon_clk,
  input  logic rst_n,
  input  logic wake_n,
  input  logic arm,
  output logic wake_seen
);
  logic                   edge_q;
  logic                   edge_clr;
  logic [SYNC_STAGES-1:0] sync_q;

  // The latch is cleared whenever the FSM is not waiting for wake, so edges
  // in the blackout or any other phase leave no trace.
  assign edge_clr = ~rst_n | ~arm;

  always_ff @(negedge wake_n or posedge edge_clr) begin
    if (edge_clr) edge_q <= 1'b0;
    else          edge_q <= 1'b1;
  end

  always_ff @(posedge aon_clk or negedge rst_n) begin
    if (!rst_n)   sync_q <= '0;
    else if (!arm) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], edge_q};
  end

  assign wake_seen = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/halt_seq_fsm.sv
module halt_seq_fsm
  import halt_seq_pkg::*;
#(
  parameter int DRAIN_MAX    = 16,
  parameter int BLACKOUT_CYC = 5,
  parameter int TO_W         = 8,
  parameter int CNT_W        = 8
) (
  input  logic            aon_clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            pipe_empty,
  input  logic            wake_seen,
  input  logic            osc_ready,
  input  logic [TO_W-1:0] osc_to_cfg,
  input  logic            src_is_xtal,
  input  logic            wd_keep,
  input  logic            relock_ack,
  output hs_state_e       state,
  output logic            xtal_l,
  output logic            keep_l,
  output logic            relock_q,
  output logic            err_q
);
  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(hs_last(DRAIN_MAX));
  localparam logic [CNT_W-1:0] BLK_LAST   = CNT_W'(hs_last(BLACKOUT_CYC));

  logic [CNT_W-1:0] cnt;
  logic             drain_end;
  logic             blk_end;
  logic             to_end;

  assign drain_end = pipe_empty || (cnt == DRAIN_LAST);
  assign blk_end   = (cnt == BLK_LAST);
  assign to_end    = (cnt == CNT_W'(osc_to_cfg));

  always_ff @(posedge aon_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      cnt      <= '0;
      xtal_l   <= 1'b0;
      keep_l   <= 1'b1;
      relock_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (relock_ack && state == ST_RUN) relock_q <= 1'b0;
      case (state)
        ST_RUN: begin
          if (halt_req) begin
            state <= ST_DRAIN;
            cnt   <= '0;
          end
        end
        ST_DRAIN: begin
          if (drain_end) begin
            state  <= ST_BLACK;
            cnt    <= '0;
            xtal_l <= src_is_xtal;
            keep_l <= wd_keep;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BLACK: begin
          if (blk_end) begin
            state <= ST_HALT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HALT: begin
          if (wake_seen) begin
            state <= ST_OSCW;
            cnt   <= '0;
          end
        end
        ST_OSCW: begin
          if (osc_ready) begin
            state    <= ST_RESUME;
            relock_q <= 1'b1;
            err_q    <= 1'b0;
          end else if (to_end) begin
            state <= ST_HALT;
            cnt   <= '0;
            err_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RESUME: state <= ST_RUN;
        default:   state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/halt_clk_ctrl.sv
module halt_clk_ctrl
  import halt_seq_pkg::*;
(
  input  hs_state_e state,
  input  logic      xtal_l,
  input  logic      keep_l,
  output logic      sysclk_en,
  output logic      periph_clk_en,
  output logic      pll_pwr_en,
  output logic      osc_en,
  output logic      intosc_en,
  output logic      wdog_en,
  output logic      in_halt,
  output logic      osc_waking,
  output logic      drain_active,
  output logic      arm,
  output logic      cpu_wake_irq
);
  always_comb begin
    sysclk_en     = 1'b1;
    periph_clk_en = 1'b1;
    pll_pwr_en    = 1'b1;
    osc_en        = 1'b1;
    intosc_en     = 1'b1;
    wdog_en       = 1'b1;
    in_halt       = 1'b0;
    osc_waking    = 1'b0;
    drain_active  = 1'b0;
    arm           = 1'b0;
    cpu_wake_irq  = 1'b0;
    case (state)
      ST_DRAIN: drain_active = 1'b1;
      ST_BLACK, ST_HALT: begin
        sysclk_en     = 1'b0;
        periph_clk_en = 1'b0;
        pll_pwr_en    = 1'b0;
        osc_en        = ~xtal_l;
        intosc_en     = keep_l;
        wdog_en       = keep_l;
        in_halt       = 1'b1;
        arm           = (state == ST_HALT);
      end
      ST_OSCW: begin
        sysclk_en     = 1'b0;
        periph_clk_en = 1'b0;
        pll_pwr_en    = 1'b0;
        wdog_en       = keep_l;
        osc_waking    = 1'b1;
      end
      ST_RESUME: cpu_wake_irq = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/halt_seq_top.sv
module halt_seq_top
  import halt_seq_pkg::*;
#(
  parameter int DRAIN_MAX    = 16,
  parameter int BLACKOUT_CYC = 5,
  parameter int TO_W         = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic            aon_clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            pipe_empty,
  input  logic            wake_n,
  input  logic            src_is_xtal,
  input  logic            wd_keep,
  input  logic            osc_ready,
  input  logic [TO_W-1:0] osc_to_cfg,
  input  logic            relock_ack,
  output logic            sysclk_en,
  output logic            periph_clk_en,
  output logic            pll_pwr_en,
  output logic            osc_en,
  output logic            intosc_en,
  output logic            wdog_en,
  output logic            in_halt,
  output logic            osc_waking,
  output logic            cpu_wake_irq,
  output logic            pll_relock_req,
  output logic            osc_err
);
  localparam int CNT_W = hs_cnt_w(DRAIN_MAX, BLACKOUT_CYC, TO_W);

  hs_state_e state;
  logic      xtal_l;
  logic      keep_l;
  logic      wake_seen;
  logic      drain_active;
  logic      arm;

  halt_wake_capture #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .aon_clk  (aon_clk),
    .rst_n    (rst_n),
    .wake_n   (wake_n),
    .arm      (arm),
    .wake_seen(wake_seen)
  );

  halt_seq_fsm #(
    .DRAIN_MAX   (DRAIN_MAX),
    .BLACKOUT_CYC(BLACKOUT_CYC),
    .TO_W        (TO_W),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .aon_clk    (aon_clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .pipe_empty (pipe_empty),
    .wake_seen  (wake_seen),
    .osc_ready  (osc_ready),
    .osc_to_cfg (osc_to_cfg),
    .src_is_xtal(src_is_xtal),
    .wd_keep    (wd_keep),
    .relock_ack (relock_ack),
    .state      (state),
    .xtal_l     (xtal_l),
    .keep_l     (keep_l),
    .relock_q   (pll_relock_req),
    .err_q      (osc_err)
  );

  halt_clk_ctrl u_ctrl (
    .state        (state),
    .xtal_l       (xtal_l),
    .keep_l       (keep_l),
    .sysclk_en    (sysclk_en),
    .periph_clk_en(periph_clk_en),
    .pll_pwr_en   (pll_pwr_en),
    .osc_en       (osc_en),
    .intosc_en    (intosc_en),
    .wdog_en      (wdog_en),
    .in_halt      (in_halt),
    .osc_waking   (osc_waking),
    .drain_active (drain_active),
    .arm          (arm),
    .cpu_wake_irq (cpu_wake_irq)
  );
endmodule

// File: rtl/halt_seq_chk.sv
module halt_seq_chk #(
  parameter int DRAIN_MAX    = 16,
  parameter int BLACKOUT_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic drain_active,
  input logic in_halt,
  input logic osc_waking,
  input logic src_is_xtal,
  input logic osc_ready,
  input logic sysclk_en,
  input logic periph_clk_en,
  input logic pll_pwr_en,
  input logic osc_en,
  input logic cpu_wake_irq,
  input logic pll_relock_req,
  input logic osc_err
);
  int dcnt;
  int hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= 0;
      hcnt <= 0;
    end else begin
      dcnt <= drain_active ? ((dcnt < DRAIN_MAX + 2) ? dcnt + 1 : dcnt) : 0;
      if (!in_halt && !osc_waking) hcnt <= 0;
      else if (in_halt && hcnt < BLACKOUT_CYC + 2) hcnt <= hcnt + 1;
    end
  end

  // R2: the drain window never runs past DRAIN_MAX cycles
  a_r2_drain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    drain_active |-> dcnt < DRAIN_MAX);

  // R3: core, peripheral and PLL stay off while halted
  a_r3_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    in_halt |-> (!sysclk_en && !periph_clk_en && !pll_pwr_en));

  // R4: a crystal source is shut down on entry from the drain window
  a_r4_xtal_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_halt) && $past(drain_active) && $past(src_is_xtal)) |-> !osc_en);

  // R6: no wake can begin within the blackout
  a_r6_blackout: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && hcnt < BLACKOUT_CYC) |=> !osc_waking);

  // R8: core clock returns only after oscillator ready, with the interrupt
  a_r8_core_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_en) |-> ($past(osc_ready) && cpu_wake_irq));

  // R9: every wake interrupt comes with the relock flag
  a_r9_relock_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wake_irq |-> pll_relock_req);

  // R10: a wait that ends without resume lands in halt with the error flag
  a_r10_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(osc_waking) && !cpu_wake_irq) |-> (in_halt && osc_err));
endmodule

bind halt_seq_top halt_seq_chk #(
  .DRAIN_MAX   (DRAIN_MAX),
  .BLACKOUT_CYC(BLACKOUT_CYC)
) u_chk (
  .clk           (aon_clk),
  .rst_n         (rst_n),
  .drain_active  (drain_active),
  .in_halt       (in_halt),
  .osc_waking    (osc_waking),
  .src_is_xtal   (src_is_xtal),
  .osc_ready     (osc_ready),
  .sysclk_en     (sysclk_en),
  .periph_clk_en (periph_clk_en),
  .pll_pwr_en    (pll_pwr_en),
  .osc_en        (osc_en),
  .cpu_wake_irq  (cpu_wake_irq),
  .pll_relock_req(pll_relock_req),
  .osc_err       (osc_err)
);

// File: tb/tb_halt_seq_top.sv
`timescale 1ns/1ps
module tb_halt_seq_top;
  localparam int DRAIN_MAX = 16;
  localparam int BLK       = 5;
  localparam int TO_W      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, pipe_empty = 1'b0, wake_n = 1'b1;
  logic src_is_xtal = 1'b0, wd_keep = 1'b0, osc_ready = 1'b0, relock_ack = 1'b0;
  logic [TO_W-1:0] osc_to_cfg = 8'd10;
  logic sysclk_en, periph_clk_en, pll_pwr_en, osc_en, intosc_en, wdog_en;
  logic in_halt, osc_waking, cpu_wake_irq, pll_relock_req, osc_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  halt_seq_top #(.DRAIN_MAX(DRAIN_MAX), .BLACKOUT_CYC(BLK), .TO_W(TO_W)) dut (
    .aon_clk(clk), .rst_n(rst_n), .halt_req(halt_req), .pipe_empty(pipe_empty),
    .wake_n(wake_n), .src_is_xtal(src_is_xtal), .wd_keep(wd_keep),
    .osc_ready(osc_ready), .osc_to_cfg(osc_to_cfg), .relock_ack(relock_ack),
    .sysclk_en(sysclk_en), .periph_clk_en(periph_clk_en), .pll_pwr_en(pll_pwr_en),
    .osc_en(osc_en), .intosc_en(intosc_en), .wdog_en(wdog_en), .in_halt(in_halt),
    .osc_waking(osc_waking), .cpu_wake_irq(cpu_wake_irq),
    .pll_relock_req(pll_relock_req), .osc_err(osc_err)
  );

  // {xtal, keep, pipe_empty drain index, expected drain length}
  localparam logic [11:0] VECS [6] = '{
    {1'b1, 1'b0, 5'd3,  5'd4},
    {1'b0, 1'b1, 5'd0,  5'd1},
    {1'b1, 1'b1, 5'd20, 5'd16},
    {1'b0, 1'b0, 5'd15, 5'd16},
    {1'b1, 1'b0, 5'd14, 5'd15},
    {1'b0, 1'b1, 5'd7,  5'd8}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Enter halt; returns measured drain length. Ends on the first halted negedge.
  task automatic enter_halt(input logic x, input logic k, input int p, output int len);
    @(negedge clk);
    src_is_xtal = x; wd_keep = k; halt_req = 1'b1; pipe_empty = 1'b0;
    @(negedge clk);
    halt_req = 1'b0;
    len = 0;
    while (sysclk_en && len < 40) begin
      len++;
      pipe_empty = (len - 1 >= p);
      @(negedge clk);
    end
    pipe_empty = 1'b0;
  endtask

  // Drop wake_n at a negedge; return negedges until osc_waking is seen.
  task automatic pull_wake(output int n);
    wake_n = 1'b0;
    n = 0;
    while (!osc_waking && n < 12) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_resume(input string tag);
    osc_ready = 1'b1;
    @(negedge clk);
    osc_ready = 1'b0;
    chk(cpu_wake_irq && sysclk_en, {tag, " R8 irq+sysclk after ready"}, {cpu_wake_irq, sysclk_en}, 3);
    chk(pll_relock_req, {tag, " R9 relock set"}, pll_relock_req, 1);
    chk(!osc_err, {tag, " R10 err clear on resume"}, osc_err, 0);
    wake_n = 1'b1;
    @(negedge clk);
    chk(!cpu_wake_irq && sysclk_en && periph_clk_en, {tag, " R8 single pulse then run"}, cpu_wake_irq, 0);
    relock_ack = 1'b1;
    @(negedge clk);
    relock_ack = 1'b0;
    chk(!pll_relock_req, {tag, " R9 relock cleared by ack"}, pll_relock_req, 0);
  endtask

  initial begin
    int len, n, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sysclk_en && periph_clk_en && pll_pwr_en && osc_en && intosc_en && wdog_en,
        "R1 enables after reset", {sysclk_en, periph_clk_en, pll_pwr_en, osc_en, intosc_en, wdog_en}, 63);
    chk(!in_halt && !osc_waking && !cpu_wake_irq && !pll_relock_req && !osc_err,
        "R1 status after reset", {in_halt, osc_waking, cpu_wake_irq, pll_relock_req, osc_err}, 0);

    foreach (VECS[i]) begin
      logic x, k;
      int p, el;
      x  = VECS[i][11];
      k  = VECS[i][10];
      p  = int'(VECS[i][9:5]);
      el = int'(VECS[i][4:0]);
      enter_halt(x, k, p, len);
      chk(len == el, "R2 drain length", len, el);
      chk(in_halt, "R2 halt after drain", in_halt, 1);
      chk(!sysclk_en && !periph_clk_en && !pll_pwr_en, "R3 gated in halt",
          {sysclk_en, periph_clk_en, pll_pwr_en}, 0);
      chk(osc_en == !x, "R4 osc enable in halt", osc_en, !x);
      chk(intosc_en == k && wdog_en == k, "R5 keep-alive in halt", {intosc_en, wdog_en}, {k, k});
      repeat (BLK + 2) @(negedge clk);
      pull_wake(n);
      chk(n == 3, "R7 wake sync latency", n, 3);
      chk(osc_en && intosc_en && !sysclk_en, "R7 oscillator on while waking",
          {osc_en, intosc_en, sysclk_en}, 6);
      finish_resume("vec");
    end

    // R6: glitch inside the blackout is discarded
    enter_halt(1'b1, 1'b0, 0, len);
    wake_n = 1'b0;
    @(negedge clk);
    wake_n = 1'b1;
    w = 0;
    repeat (12) begin
      @(negedge clk);
      if (osc_waking) w++;
    end
    chk(w == 0, "R6 blackout wake ignored", w, 0);
    chk(in_halt && !osc_en, "R6 still halted", {in_halt, osc_en}, 2);
    pull_wake(n);
    chk(n == 3, "R7 wake after blackout", n, 3);
    finish_resume("blk");

    // R10: oscillator never ready -> timeout back to halt
    osc_to_cfg = 8'd6;
    enter_halt(1'b0, 1'b1, 2, len);
    repeat (BLK + 2) @(negedge clk);
    pull_wake(n);
    w = 0;
    while (osc_waking && w < 30) begin
      w++;
      @(negedge clk);
    end
    chk(w == 7, "R10 wait length", w, 7);
    chk(in_halt && osc_err, "R10 back in halt with error", {in_halt, osc_err}, 3);
    chk(!sysclk_en && !cpu_wake_irq, "R8 no core clock without ready", {sysclk_en, cpu_wake_irq}, 0);
    wake_n = 1'b1;
    repeat (3) @(negedge clk);
    pull_wake(n);
    chk(n == 3, "R7 second wake", n, 3);
    finish_resume("to");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule